// File: doc/BRIEF.md
# Convolver Control Register File

This block is the configuration store of a 3x3 image convolver. A host processor writes it through a 10-bit data bus, a 3-bit address, an active-low chip select and an active-low load strobe. A write completes when the load strobe is released. The block holds five things: an ALU microcode word, a row-length value, an initialization word, and two banks of nine 8-bit kernel coefficients. Each bank fills through an internal tap pointer, so nine writes to one address load taps A through I. A separate 8-bit ALU operand register loads from the low data bits on any clock edge at which its own enable is high.

The row length has a special rule. It accepts one write per reset. If no write arrives within a fixed number of clocks after reset is released, it locks at zero. The data path decodes the meaning of every field; this block only exports the stored contents.

Top module: `conv_cfg_regs`

## Requirements
- R1: A register write happens on the first clock edge at which `ld_n` is sampled high, provided that `ld_n` and `cs_n` were both sampled low at the edge before. Holding `ld_n` low changes no register.
- R2: While `cs_n` is high, toggling `ld_n` changes no register.
- R3: Stored widths are 10 bits for microcode, 10 bits for row length and 9 bits for the initialization word (data bit 9 is dropped). Each coefficient is 8 bits, taken from data bits 7:0.
- R4: After an active-low `rst_n`, microcode reads 10'b0000011000 and every other output reads 0. `row_lock_o` also reads 0.
- R5: After one accepted row-length write, `row_lock_o` is 1 and later row-length writes are ignored until the next reset.
- R6: If no row-length write occurs within 1024 clocks after reset release, the row length stays 0 and `row_lock_o` rises. After that, writes to the row length are ignored.
- R7: The address map is 0 = microcode, 1 = row length, 2 = initialization, 3 = coefficient bank 0, 4 = coefficient bank 1. Writes to addresses 5 to 7 change nothing.
- R8: Successive writes to one bank address fill taps A..I in order and then wrap back to A. Tap A appears at bits 7:0 of the bank output and tap I at bits 71:64.
- R9: If the previous write went to a different address, a write to a bank address lands in tap A.
- R10: At a clock edge where `alu_en` is high, `alu_op_o` takes `cfg_data[7:0]`. Otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_data | input | 10 | Write data bus |
| cfg_addr | input | 3 | Register address |
| cs_n | input | 1 | Active-low chip select |
| ld_n | input | 1 | Active-low load strobe; a write completes on its release |
| alu_en | input | 1 | ALU operand register load enable |
| ucode_o | output | 10 | ALU microcode word |
| rowlen_o | output | 10 | Row-length value |
| init_o | output | 9 | Initialization word |
| coef0_o | output | 72 | Coefficient bank 0, tap A in bits 7:0 |
| coef1_o | output | 72 | Coefficient bank 1, tap A in bits 7:0 |
| alu_op_o | output | 8 | ALU operand register |
| row_lock_o | output | 1 | Row length is locked |

## Verification
Some properties are checked on every cycle:
- a chip select that was high at the previous sample blocks any write event;
- the microcode word moves only on a write event to its own address;
- a locked row length never changes;
- the lock is always set once 1024 clocks have passed since reset;
- the ALU operand register follows its enable exactly.

Other behaviour only the bench scenarios can show:
- the tap pointer order and its wrap;
- the pointer restart after an address change;
- the dropped high data bits;
- the reset defaults;
- the silence of the unused addresses.

// File: rtl/cfgreg_pkg.sv
package cfgreg_pkg;
  localparam int unsigned CIN_W     = 10;
  localparam int unsigned ADDR_W    = 3;
  localparam int unsigned COEF_W    = 8;
  localparam int unsigned TAPS      = 9;
  localparam int unsigned UCODE_W   = 10;
  localparam int unsigned ROWLEN_W  = 10;
  localparam int unsigned INIT_W    = 9;
  localparam int unsigned AUTO_LOCK = 1024;
  localparam logic [UCODE_W-1:0] UCODE_DEFAULT = 10'b0000011000;

  typedef enum logic [ADDR_W-1:0] {
    RA_UCODE  = 3'd0,
    RA_ROWLEN = 3'd1,
    RA_INIT   = 3'd2,
    RA_BANK0  = 3'd3,
    RA_BANK1  = 3'd4
  } reg_addr_e;

  // Address of coefficient bank b
  function automatic logic [ADDR_W-1:0] bank_addr(input int unsigned b);
    return (b == 0) ? RA_BANK0 : RA_BANK1;
  endfunction
endpackage

// File: rtl/cfg_strobe_detect.sv
module cfg_strobe_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic ld_n,
  output logic wr_ev
);
  logic armed_q;

  // Armed when both strobes were low at the last sample
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= ~ld_n & ~cs_n;
  end

  // Write completes when load is seen released
  assign wr_ev = armed_q & ld_n;
endmodule

// File: rtl/cfg_coef_bank.sv
module cfg_coef_bank #(
  parameter int unsigned TAPS   = 9,
  parameter int unsigned COEF_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr,
  input  logic                     restart,
  input  logic [COEF_W-1:0]        wdata,
  output logic [TAPS*COEF_W-1:0]   coef_o
);
  localparam int unsigned IDX_W = (TAPS > 1) ? $clog2(TAPS) : 1;

  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] tap_use;

  function automatic logic [IDX_W-1:0] tap_next(input logic [IDX_W-1:0] cur);
    return (cur == IDX_W'(TAPS-1)) ? '0 : cur + 1'b1;
  endfunction

  assign tap_use = restart ? '0 : idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  idx_q <= '0;
    else if (wr) idx_q <= tap_next(tap_use);
  end

  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    logic [COEF_W-1:0] c_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              c_q <= '0;
      else if (wr && tap_use == IDX_W'(t))     c_q <= wdata;
    end
    assign coef_o[t*COEF_W +: COEF_W] = c_q;
  end
endmodule

// File: rtl/cfg_rowlen_guard.sv
module cfg_rowlen_guard #(
  parameter int unsigned ROWLEN_W = 10,
  parameter int unsigned LIMIT    = 1024
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic [ROWLEN_W-1:0] wdata,
  output logic [ROWLEN_W-1:0] rowlen_o,
  output logic                locked_o
);
  localparam int unsigned CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic             timeout;
  logic             accept;

  assign timeout = (cnt_q == CNT_W'(LIMIT-1));
  assign accept  = wr & ~locked_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      locked_o <= 1'b0;
      rowlen_o <= '0;
    end else if (!locked_o) begin
      cnt_q <= cnt_q + 1'b1;
      if (accept) begin
        rowlen_o <= wdata;
        locked_o <= 1'b1;
      end else if (timeout) begin
        rowlen_o <= '0;
        locked_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/conv_cfg_regs.sv
module conv_cfg_regs
  import cfgreg_pkg::*;
#(
  parameter int unsigned DW    = CIN_W,
  parameter int unsigned AW    = ADDR_W,
  parameter int unsigned CW    = COEF_W,
  parameter int unsigned NTAP  = TAPS,
  parameter int unsigned UW    = UCODE_W,
  parameter int unsigned RW    = ROWLEN_W,
  parameter int unsigned IW    = INIT_W,
  parameter int unsigned LOCKT = AUTO_LOCK
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DW-1:0]      cfg_data,
  input  logic [AW-1:0]      cfg_addr,
  input  logic               cs_n,
  input  logic               ld_n,
  input  logic               alu_en,
  output logic [UW-1:0]      ucode_o,
  output logic [RW-1:0]      rowlen_o,
  output logic [IW-1:0]      init_o,
  output logic [NTAP*CW-1:0] coef0_o,
  output logic [NTAP*CW-1:0] coef1_o,
  output logic [CW-1:0]      alu_op_o,
  output logic               row_lock_o
);
  localparam int unsigned NBANK = 2;

  logic          wr_ev;
  logic [AW-1:0] last_addr_q;
  logic          wr_ucode, wr_rowlen, wr_init;
  logic [NTAP*CW-1:0] bank_out [NBANK];

  cfg_strobe_detect u_strobe (
    .clk   (clk),
    .rst_n (rst_n),
    .cs_n  (cs_n),
    .ld_n  (ld_n),
    .wr_ev (wr_ev)
  );

  assign wr_ucode  = wr_ev && (cfg_addr == RA_UCODE);
  assign wr_rowlen = wr_ev && (cfg_addr == RA_ROWLEN);
  assign wr_init   = wr_ev && (cfg_addr == RA_INIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       last_addr_q <= '0;
    else if (wr_ev)   last_addr_q <= cfg_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ucode_o <= UCODE_DEFAULT;
    else if (wr_ucode)  ucode_o <= cfg_data[UW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        init_o <= '0;
    else if (wr_init)  init_o <= cfg_data[IW-1:0];
  end

  cfg_rowlen_guard #(.ROWLEN_W(RW), .LIMIT(LOCKT)) u_rowlen (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (wr_rowlen),
    .wdata    (cfg_data[RW-1:0]),
    .rowlen_o (rowlen_o),
    .locked_o (row_lock_o)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic hit;
    logic restart;
    assign hit     = wr_ev && (cfg_addr == bank_addr(b));
    assign restart = (last_addr_q != bank_addr(b));
    cfg_coef_bank #(.TAPS(NTAP), .COEF_W(CW)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (hit),
      .restart (restart),
      .wdata   (cfg_data[CW-1:0]),
      .coef_o  (bank_out[b])
    );
  end

  assign coef0_o = bank_out[0];
  assign coef1_o = bank_out[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       alu_op_o <= '0;
    else if (alu_en)  alu_op_o <= cfg_data[CW-1:0];
  end
endmodule

// File: rtl/conv_cfg_regs_chk.sv
module conv_cfg_regs_chk
  import cfgreg_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [CIN_W-1:0]   cfg_data,
  input logic [ADDR_W-1:0]  cfg_addr,
  input logic               cs_n,
  input logic               alu_en,
  input logic               wr_ev,
  input logic [UCODE_W-1:0] ucode_o,
  input logic [ROWLEN_W-1:0] rowlen_o,
  input logic               row_lock_o,
  input logic [COEF_W-1:0]  alu_op_o
);
  logic [11:0] cyc_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cyc_q <= '0;
    else if (cyc_q != 12'hFFF)         cyc_q <= cyc_q + 1'b1;
  end

  AST_CS_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n) |-> !wr_ev); // R2

  AST_UCODE_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ev && cfg_addr == RA_UCODE) |=> $stable(ucode_o)); // R1

  AST_ROWLEN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    row_lock_o |=> $stable(rowlen_o) && row_lock_o); // R5

  AST_AUTO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q >= 12'(AUTO_LOCK)) |-> row_lock_o); // R6

  AST_ALU_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    alu_en |=> alu_op_o == $past(cfg_data[COEF_W-1:0])); // R10

  AST_ALU_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !alu_en |=> $stable(alu_op_o)); // R10
endmodule

bind conv_cfg_regs conv_cfg_regs_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_data   (cfg_data),
  .cfg_addr   (cfg_addr),
  .cs_n       (cs_n),
  .alu_en     (alu_en),
  .wr_ev      (wr_ev),
  .ucode_o    (ucode_o),
  .rowlen_o   (rowlen_o),
  .row_lock_o (row_lock_o),
  .alu_op_o   (alu_op_o)
);

// File: tb/sim_conv_cfg_regs.sv
module sim_conv_cfg_regs;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  cfg_data = '0;
  logic [2:0]  cfg_addr = '0;
  logic        cs_n = 1'b1;
  logic        ld_n = 1'b1;
  logic        alu_en = 1'b0;
  logic [9:0]  ucode_o, rowlen_o;
  logic [8:0]  init_o;
  logic [71:0] coef0_o, coef1_o;
  logic [7:0]  alu_op_o;
  logic        row_lock_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  conv_cfg_regs u0 (
    .clk(clk), .rst_n(rst_n), .cfg_data(cfg_data), .cfg_addr(cfg_addr),
    .cs_n(cs_n), .ld_n(ld_n), .alu_en(alu_en), .ucode_o(ucode_o),
    .rowlen_o(rowlen_o), .init_o(init_o), .coef0_o(coef0_o),
    .coef1_o(coef1_o), .alu_op_o(alu_op_o), .row_lock_o(row_lock_o)
  );

  // obs: 0 ucode, 1 rowlen, 2 init, 3 bank0 tap, 4 bank1 tap
  typedef struct packed {
    logic [2:0] addr;
    logic [9:0] data;
    logic [2:0] obs;
    logic [3:0] tap;
    logic [9:0] exp;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VT [NV] = '{
    '{3'd0, 10'h3A5, 3'd0, 4'd0, 10'h3A5},  // R3 R7 microcode
    '{3'd2, 10'h3FF, 3'd2, 4'd0, 10'h1FF},  // R3 init drops bit 9
    '{3'd1, 10'h123, 3'd1, 4'd0, 10'h123},  // R7 row length
    '{3'd1, 10'h055, 3'd1, 4'd0, 10'h123},  // R5 second write ignored
    '{3'd3, 10'h311, 3'd3, 4'd0, 10'h011},  // R3 low byte only
    '{3'd3, 10'h022, 3'd3, 4'd1, 10'h022},  // R8 tap B
    '{3'd4, 10'h0A0, 3'd4, 4'd0, 10'h0A0},  // R7 bank1 tap A
    '{3'd3, 10'h033, 3'd3, 4'd0, 10'h033},  // R9 restart at A
    '{3'd3, 10'h044, 3'd3, 4'd1, 10'h044},  // R9 then B
    '{3'd5, 10'h2AA, 3'd0, 4'd0, 10'h3A5},  // R7 unused address
    '{3'd0, 10'h000, 3'd0, 4'd0, 10'h000}   // R7 microcode cleared
  };

  function automatic logic [9:0] observe(input logic [2:0] obs, input logic [3:0] tap);
    case (obs)
      3'd0:    return ucode_o;
      3'd1:    return rowlen_o;
      3'd2:    return {1'b0, init_o};
      3'd3:    return {2'b0, coef0_o[tap*8 +: 8]};
      default: return {2'b0, coef1_o[tap*8 +: 8]};
    endcase
  endfunction

  task automatic check(input string req, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [2:0] a, input logic [9:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_data = d; cs_n = 1'b0; ld_n = 1'b0;
    @(negedge clk);
    ld_n = 1'b1;
    @(negedge clk);
    cs_n = 1'b1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R4 reset defaults
    check("R4 ucode", {62'b0, ucode_o}, 72'h018);
    check("R4 others", {rowlen_o, init_o, alu_op_o, row_lock_o}, '0);
    check("R4 banks", coef0_o | coef1_o, '0);

    for (int i = 0; i < NV; i++) begin
      do_write(VT[i].addr, VT[i].data);
      check($sformatf("vector %0d R3/R5/R7/R8/R9", i),
            {62'b0, observe(VT[i].obs, VT[i].tap)}, {62'b0, VT[i].exp});
    end

    // R1: no change while load held low, change on release
    @(negedge clk);
    cfg_addr = 3'd0; cfg_data = 10'h155; cs_n = 1'b0; ld_n = 1'b0;
    @(negedge clk);
    check("R1 held low", {62'b0, ucode_o}, 72'h000);
    ld_n = 1'b1;
    @(negedge clk);
    cs_n = 1'b1;
    check("R1 release", {62'b0, ucode_o}, 72'h155);

    // R2: chip select high blocks writes
    @(negedge clk);
    cfg_addr = 3'd0; cfg_data = 10'h2F0; cs_n = 1'b1; ld_n = 1'b0;
    @(negedge clk);
    ld_n = 1'b1;
    @(negedge clk);
    check("R2 cs high", {62'b0, ucode_o}, 72'h155);

    // R8: fill bank1 A..I, then wrap
    do_write(3'd0, 10'h155);
    for (int k = 1; k <= 9; k++) do_write(3'd4, 10'(k));
    check("R8 fill", coef1_o, 72'h090807060504030201);
    do_write(3'd4, 10'h077);
    check("R8 wrap", coef1_o, 72'h090807060504030277);

    // R10: operand register load and hold
    @(negedge clk);
    cfg_data = 10'h3C8; alu_en = 1'b1;
    @(negedge clk);
    alu_en = 1'b0; cfg_data = 10'h011;
    check("R10 load", {64'b0, alu_op_o}, 72'hC8);
    @(negedge clk);
    check("R10 hold", {64'b0, alu_op_o}, 72'hC8);

    // R6: auto-lock with no row-length write
    do_reset();
    repeat (1000) @(negedge clk);
    check("R6 before window end", {71'b0, row_lock_o}, 72'h0);
    repeat (40) @(negedge clk);
    check("R6 locked", {71'b0, row_lock_o}, 72'h1);
    do_write(3'd1, 10'h0AB);
    check("R6 write ignored", {62'b0, rowlen_o}, 72'h0);

    // R5: lock after early write
    do_reset();
    do_write(3'd1, 10'h2C4);
    check("R5 lock flag", {71'b0, row_lock_o}, 72'h1);
    do_write(3'd1, 10'h001);
    check("R5 ignored", {62'b0, rowlen_o}, 72'h2C4);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule